// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block converts a parallel word into a serial bit stream inside a design that runs from one system clock. Three control pins from outside the clock domain (a shift clock, a clock-inhibit and an active-low load strobe) are each brought in through a two-flop synchroniser. The shift clock and the inhibit are ORed into one effective clock. The datapath advances by one stage on each rising edge of that effective clock, which the block finds by comparing the synchronised value with a registered copy.

While the load strobe is low, the stages take the parallel word, whatever the clock, inhibit and serial pins are doing. While it is high, the register holds or shifts. On a shift the serial input enters the first stage and every stage passes its bit one step toward the last stage. The last stage is driven out both true and inverted.

The parallel word and the serial input are sampled directly on the system clock edge that performs the load or the shift. They must be stable around that edge.

Top module: `psr_shifter`

## Requirements
- R1: A synchronous active-low reset clears every stage to 0, so `q_last`=0 and `q_last_n`=1. The edge history resets to the idle high level, so releasing reset with the shift clock high produces no shift.
- R2: While the synchronised load strobe is low, stage i takes `par_in[i]`. Bit 0 is the first stage and bit WIDTH-1 is the last stage, so `q_last` shows `par_in[WIDTH-1]`.
- R3: While loading, toggles of the shift clock, the inhibit or the serial input have no effect. The parallel word is followed level-sensitively.
- R4: When the load strobe is high, a rising edge of (shift clock OR inhibit) shifts once. Stage i+1 takes stage i, and stage 0 takes `ser_in`.
- R5: While the inhibit is held high, pulses on the shift clock cause no shift.
- R6: While the shift clock is held low, a rising inhibit acts as the clock and shifts once.
- R7: Raising the inhibit while the shift clock is high causes no shift. Falling edges of the effective clock never shift.
- R8: With no load and no rising effective edge, every stage keeps its value.
- R9: `q_last_n` is always the complement of `q_last`.
- R10: A pin change takes effect at the third system clock edge after it, and the outputs change only then. `ser_in` and `par_in` are sampled at that edge.
- R11: If a load and a rising effective edge reach the datapath in the same cycle, the load wins and no shift happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_in | input | WIDTH | Parallel word; bit 0 goes to the first stage |
| ser_in | input | 1 | Serial bit entering the first stage on a shift |
| shclk_pin | input | 1 | Asynchronous shift clock |
| inhibit_pin | input | 1 | Asynchronous clock inhibit, ORed with the shift clock |
| load_n_pin | input | 1 | Asynchronous active-low load strobe |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Inverted last stage |

## Verification
The bench targets several corner cases.
- Releasing reset with the shift clock high: a design that seeds its edge history low inserts a phantom shift, which shows up seven shifts later as a stray 1.
- Raising the inhibit while the shift clock is high: a design that edge-detects the pins separately shifts here.
- Holding the shift clock low: a design that ignores the inhibit as a clock source misses shifts.
- A one-cycle load strobe that lands on the same cycle as a clock edge: a design where the shift wins ends up holding a shifted word instead of the parallel one.
- The exact three-edge latency: an extra or a missing synchroniser stage moves the output change by one cycle.

// File: rtl/psr_pkg.sv
// Shared types for the parallel-to-serial shift register.
// Assumes nothing beyond IEEE 1800-2017.
package psr_pkg;

    // Action taken by the datapath in one system cycle.
    typedef enum logic [1:0] {
        PSR_HOLD  = 2'd0,
        PSR_SHIFT = 2'd1,
        PSR_LOAD  = 2'd2
    } psr_act_e;

    // Choose the datapath action; load has priority over shift.
    function automatic psr_act_e psr_pick(input logic load_req, input logic shift_req);
        if (load_req)       return PSR_LOAD;
        else if (shift_req) return PSR_SHIFT;
        else                return PSR_HOLD;
    endfunction

endpackage

// File: rtl/psr_sync.sv
// Multi-flop synchroniser for a bundle of asynchronous pins.
// Assumes each bit is independent; no cross-bit coherence is promised.
// The reset value is a parameter so idle levels can be chosen per bit.
module psr_sync #(
    parameter int               WIDTH     = 1,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: capture the raw pin level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RESET_VAL;
                else        chain[0] <= d_async;
            end
        end else begin : g_next
            // Later flops: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RESET_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/psr_edge.sv
// Effective-clock rising-edge detector.
// Forms (shift clock OR inhibit) from synchronised inputs and flags one
// cycle when it goes from low to high. History resets high (idle) so
// reset release never produces an edge.
module psr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic shclk_s,
    input  logic inhibit_s,
    output logic rise
);

    logic eff_now;
    logic eff_prev;

    // Combine the two clock sources; either high blocks the other.
    assign eff_now = shclk_s | inhibit_s;

    // Remember last cycle's effective level.
    always_ff @(posedge clk) begin
        if (!rst_n) eff_prev <= 1'b1;
        else        eff_prev <= eff_now;
    end

    assign rise = eff_now & ~eff_prev;

    // R7: a shift clock high for two cycles cannot yield an edge.
    assert_no_rise_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shclk_s && $past(shclk_s)) |-> !rise);

    // R5: an inhibit held high for two cycles blocks any edge.
    assert_inhibit_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_s && $past(inhibit_s)) |-> !rise);

    // R1: the first cycle after reset release never reports an edge.
    assert_no_edge_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rise);

endmodule

// File: rtl/psr_stages.sv
// Shift/load datapath of WIDTH stages.
// Stage 0 is the first stage and receives the serial bit; stage WIDTH-1
// drives the outputs. Load overrides shift. Assumes load_req and
// shift_req are already synchronous to clk.
module psr_stages
    import psr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic             shift_req,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             q_last,
    output logic             q_last_n
);

    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] stages;
    psr_act_e         act;

    // Decode this cycle's action with load priority.
    always_comb act = psr_pick(load_req, shift_req);

    // Update the stage register according to the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else begin
            case (act)
                PSR_LOAD:  stages <= par_in;
                PSR_SHIFT: stages <= {stages[LAST-1:0], ser_in};
                default:   stages <= stages;
            endcase
        end
    end

    // Drive the last stage true and inverted.
    assign q_last   = stages[LAST];
    assign q_last_n = ~stages[LAST];

    // R2: a load copies the parallel word.
    assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> (stages == $past(par_in)));

    // R4: a shift moves every bit one stage and takes the serial bit.
    assert_shift_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && shift_req) |=> (stages == {$past(stages[LAST-1:0]), $past(ser_in)}));

    // R8: no request leaves the register untouched.
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req && !shift_req) |=> $stable(stages));

    // R11: load and edge in one cycle yield the parallel word.
    assert_load_beats_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && shift_req) |=> (stages == $past(par_in)));

endmodule

// File: rtl/psr_shifter.sv
// Top: gated-clock parallel-in, serial-out shift register.
// Synchronises the three control pins, detects rising edges of the
// effective clock and drives the stage datapath. par_in and ser_in are
// sampled directly and must be stable at the acting edge.
module psr_shifter #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    input  logic             shclk_pin,
    input  logic             inhibit_pin,
    input  logic             load_n_pin,
    output logic             q_last,
    output logic             q_last_n
);

    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_s;
    logic             edge_rise;

    assign pins_raw = {load_n_pin, inhibit_pin, shclk_pin};

    psr_sync #(
        .WIDTH     (NPINS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({NPINS{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_raw),
        .d_sync  (pins_s)
    );

    psr_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .shclk_s   (pins_s[0]),
        .inhibit_s (pins_s[1]),
        .rise      (edge_rise)
    );

    psr_stages #(
        .WIDTH (WIDTH)
    ) u_stages (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (~pins_s[2]),
        .shift_req (edge_rise),
        .par_in    (par_in),
        .ser_in    (ser_in),
        .q_last    (q_last),
        .q_last_n  (q_last_n)
    );

endmodule

// File: tb/psr_shifter_test.sv
module psr_shifter_test;

    localparam int W = 8;
    localparam int NVEC = 6;
    // Each vector: {parallel word, serial pattern}.
    localparam logic [15:0] VEC [NVEC] = '{
        16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_5A, 16'h6E_C3, 16'h1F_96
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] par_in = '0;
    logic ser_in = 1'b0;
    logic shclk_pin = 1'b0;
    logic inhibit_pin = 1'b0;
    logic load_n_pin = 1'b1;
    logic q_last, q_last_n;

    logic [W-1:0] model = '0;
    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    psr_shifter #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
        .shclk_pin(shclk_pin), .inhibit_pin(inhibit_pin), .load_n_pin(load_n_pin),
        .q_last(q_last), .q_last_n(q_last_n)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        total++;
        if (q_last !== exp || q_last_n !== ~exp) begin
            fails++;
            $display("FAIL %s: q_last=%b q_last_n=%b expected q_last=%b q_last_n=%b",
                     tag, q_last, q_last_n, exp, ~exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] v);
        par_in = v; load_n_pin = 1'b0; wait_n(3);
        load_n_pin = 1'b1; wait_n(3);
        model = v;
    endtask

    // One shift-clock pulse; the shift lands at the third edge.
    task automatic pulse(input logic s);
        ser_in = s; shclk_pin = 1'b1; wait_n(3);
        model = {model[W-2:0], s};
        shclk_pin = 1'b0; wait_n(3);
    endtask

    initial begin
        wait_n(400000);
        fails++; total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1: reset with shift clock high and serial high.
        shclk_pin = 1'b1; ser_in = 1'b1;
        wait_n(4);
        chk(1'b0, "R1 reset state");
        rst_n = 1'b1;
        wait_n(8);
        chk(1'b0, "R1 after release");
        shclk_pin = 1'b0; wait_n(3);
        for (int k = 0; k < W - 1; k++) pulse(1'b0);
        chk(model[W-1], "R1 no phantom shift at release");

        // Vector table: load, then shift the word out and the pattern in.
        for (int v = 0; v < NVEC; v++) begin
            do_load(VEC[v][15:8]);
            chk(model[W-1], "R2 load shows last bit");
            for (int s = 0; s < 2 * W - 1; s++) begin
                pulse(VEC[v][s % 8]);
                chk(model[W-1], "R4 shift stream");
            end
        end

        // R10: output changes at the third edge, not the second.
        do_load(8'h7F);
        chk(1'b0, "R10 pre");
        ser_in = 1'b0; shclk_pin = 1'b1; wait_n(2);
        chk(1'b0, "R10 not before third edge");
        wait_n(1);
        model = {model[W-2:0], 1'b0};
        chk(1'b1, "R10 at third edge");
        shclk_pin = 1'b0; wait_n(3);

        // R7 and R5: raise inhibit while the clock is high, then pulse.
        do_load(8'hA5);
        pulse(1'b0);
        shclk_pin = 1'b1; ser_in = 1'b1; wait_n(3);
        model = {model[W-2:0], 1'b1};
        chk(model[W-1], "R4 shift before inhibit");
        inhibit_pin = 1'b1; wait_n(3);
        chk(model[W-1], "R7 inhibit raised under high clock");
        for (int k = 0; k < 3; k++) begin
            shclk_pin = 1'b0; wait_n(3);
            shclk_pin = 1'b1; wait_n(3);
            chk(model[W-1], "R5 inhibited pulse");
        end
        shclk_pin = 1'b0; wait_n(3);
        inhibit_pin = 1'b0; wait_n(3);
        chk(model[W-1], "R7 falling effective clock");
        for (int k = 0; k < W - 1; k++) pulse(1'b0);
        chk(model[W-1], "R5 contents intact");

        // R6: inhibit acts as the clock while the shift clock is low.
        do_load(8'h0F);
        for (int k = 0; k < 5; k++) begin
            ser_in = k[0]; inhibit_pin = 1'b1; wait_n(3);
            model = {model[W-2:0], k[0]};
            inhibit_pin = 1'b0; wait_n(3);
            chk(model[W-1], "R6 inhibit as clock");
        end

        // R3: load overrides clock activity and follows the word.
        par_in = 8'h3C; load_n_pin = 1'b0; wait_n(3);
        chk(1'b0, "R3 load active");
        ser_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            shclk_pin = 1'b1; inhibit_pin = 1'b0; wait_n(2);
            shclk_pin = 1'b0; wait_n(2);
            chk(1'b0, "R3 clock toggles while loading");
        end
        par_in = 8'hC3; wait_n(3);
        chk(1'b1, "R3 level-sensitive load");
        load_n_pin = 1'b1; wait_n(3);
        model = 8'hC3;
        for (int k = 0; k < W - 1; k++) begin
            pulse(1'b0);
            chk(model[W-1], "R3 loaded word shifts out");
        end

        // R11: one-cycle load coincides with a clock edge.
        par_in = 8'h81; ser_in = 1'b1;
        load_n_pin = 1'b0; shclk_pin = 1'b1; wait_n(1);
        load_n_pin = 1'b1; wait_n(4);
        model = 8'h81;
        chk(1'b1, "R11 load wins");
        shclk_pin = 1'b0; wait_n(3);
        for (int k = 0; k < W - 1; k++) begin
            pulse(1'b0);
            chk(model[W-1], "R11 word intact");
        end

        // R8 and R9: idle period holds the state.
        do_load(8'hB6);
        wait_n(20);
        chk(model[W-1], "R8 hold idle");
        for (int k = 0; k < W - 1; k++) begin
            pulse(1'b1);
            chk(model[W-1], "R9 complement during shift-out");
        end

        // R1: reset in mid-run clears the stages.
        rst_n = 1'b0; wait_n(2);
        chk(1'b0, "R1 mid-run reset");
        rst_n = 1'b1; wait_n(4);
        model = '0;
        chk(1'b0, "R1 after second release");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule